// File: doc/BRIEF.md
# Table Read Address Unit

This block serves the table-read instructions of a small 8-bit core whose program memory holds 16-bit words. When one of the two read instructions is strobed, the unit builds a 12-bit program-memory address from the low table pointer and a page number. The page number comes from one of three places. A current-page read normally takes the page from the upper bits of the program counter. When a configuration bit turns on the high table pointer, a current-page read takes the page from the low nibble of that pointer instead. A last-page read always uses the top page of memory.

The read takes two cycles. In the first cycle the strobe is accepted and the address is registered. In the second cycle the unit drives the program-memory read port and presents the low byte of the fetched word, with a write enable, for the destination data register. At the end of that cycle it latches the high byte into a read-only holding register.

Strobes that arrive while a read is in progress are dropped. The busy output tells the core to stall its fetch for the second cycle.

Top module: `tbl_read_unit`

## Requirements
- R1: With the high-pointer enable at 0, a current-page read addresses {pcPage, tblPtrLo}, where pcPage is bits 11:8 of the program counter and tblPtrLo supplies bits 7:0.
- R2: With the high-pointer enable at 1, a current-page read addresses {tblPtrHi[3:0], tblPtrLo}; bits 7:4 of tblPtrHi are ignored.
- R3: A last-page read addresses {4'hF, tblPtrLo}, which lies in 0xF00 to 0xFFF, whatever the values of pcPage, tblPtrHi and the enable.
- R4: With the high-pointer enable at 0, the value on tblPtrHi has no effect on the address.
- R5: In the second cycle of a read, dstWe is 1 and dstData equals bits 7:0 of memData. In every other cycle dstWe is 0.
- R6: At the end of the second cycle, tblHigh loads bits 15:8 of memData. At all other times it keeps its value.
- R7: An accepted strobe makes busy and memRdEn 1 for exactly the next cycle, with memAddr holding the formed address in that cycle.
- R8: A strobe that is present while busy is 1 is ignored: no new read starts and the address does not change.
- R9: If both strobes are 1 in the same cycle, the last-page read wins.
- R10: After reset, busy, memRdEn and dstWe are 0, and tblHigh and memAddr are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rdCurPage | input | 1 | Strobe for the current-page table read |
| rdLastPage | input | 1 | Strobe for the last-page table read |
| hiPtrEn | input | 1 | Configuration bit that enables the high table pointer |
| pcPage | input | 4 | Program counter bits 11:8 |
| tblPtrLo | input | 8 | Low table pointer |
| tblPtrHi | input | 8 | High table pointer |
| memAddr | output | 12 | Program-memory read address |
| memRdEn | output | 1 | Program-memory read enable |
| memData | input | 16 | Word returned by program memory |
| busy | output | 1 | Stall request for the second cycle |
| dstWe | output | 1 | Write enable for the destination register |
| dstData | output | 8 | Low byte of the fetched word |
| tblHigh | output | 8 | Read-only high-byte holding register |

## Verification
A strobe is accepted at one clock edge. The address, memRdEn, busy, dstWe and dstData are then due in the cycle that follows that edge. tblHigh is due only after the second edge. The bench drives its inputs on falling edges. It checks the second-cycle outputs at the falling edge halfway through that cycle, and it checks tblHigh and the return of busy to 0 one full cycle later. The bench's program-memory model gives each address a distinct word, so every check on data also confirms which address was used.

// File: rtl/tbl_read_pkg.sv
package tbl_read_pkg;
  // control-to-datapath strobes
  typedef struct packed {
    logic loadAddr;   // accept a new read, register its address
    logic forceLast;  // address the last page
    logic capture;    // second cycle: memory word is valid
  } tblStrobe_t;
endpackage

// File: rtl/tbl_read_ctrl.sv
module tbl_read_ctrl
  import tbl_read_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rdCurPage,
  input  logic       rdLastPage,
  output tblStrobe_t strb,
  output logic       busy
);
  logic fetching;
  logic accept;

  assign accept = (rdCurPage | rdLastPage) & ~fetching;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) fetching <= 1'b0;
    else       fetching <= accept;
  end

  always_comb begin
    strb.loadAddr  = accept;
    strb.forceLast = rdLastPage;   // last page has priority
    strb.capture   = fetching;
  end
  assign busy = fetching;

  // R7: the second cycle lasts exactly one cycle
  a_r7_busy_single: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !busy);
  // R7: an accepted strobe leads to the second cycle
  a_r7_accept_busy: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && (rdCurPage || rdLastPage)) |=> busy);
  // R8: strobes during the second cycle start nothing
  a_r8_ignore_busy: assert property (@(posedge clk) disable iff (!rstN)
    (busy && (rdCurPage || rdLastPage)) |=> !busy);
endmodule

// File: rtl/tbl_read_dp.sv
module tbl_read_dp
  import tbl_read_pkg::*;
#(
  parameter int PAGE_W = 4,
  parameter int PTR_W  = 8,
  parameter int WORD_W = 16,
  parameter int DATA_W = 8,
  localparam int ADDR_W = PAGE_W + PTR_W,
  localparam int HI_W   = WORD_W - DATA_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  tblStrobe_t        strb,
  input  logic              hiPtrEn,
  input  logic [PAGE_W-1:0] pcPage,
  input  logic [PTR_W-1:0]  tblPtrLo,
  input  logic [PTR_W-1:0]  tblPtrHi,
  input  logic [WORD_W-1:0] memData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRdEn,
  output logic              dstWe,
  output logic [DATA_W-1:0] dstData,
  output logic [DATA_W-1:0] tblHigh
);
  logic [ADDR_W-1:0] addrReg;
  logic [PAGE_W-1:0] pageSel;
  logic [DATA_W-1:0] hiPart;

  always_comb begin
    if (strb.forceLast)  pageSel = {PAGE_W{1'b1}};
    else if (hiPtrEn)    pageSel = tblPtrHi[PAGE_W-1:0];
    else                 pageSel = pcPage;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              addrReg <= '0;
    else if (strb.loadAddr) addrReg <= {pageSel, tblPtrLo};
  end

  // high part of the word, zero-filled when narrower than a byte
  generate
    if (HI_W >= DATA_W) begin : g_hiFull
      assign hiPart = memData[DATA_W +: DATA_W];
    end else begin : g_hiPad
      assign hiPart = {{(DATA_W-HI_W){1'b0}}, memData[WORD_W-1:DATA_W]};
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             tblHigh <= '0;
    else if (strb.capture) tblHigh <= hiPart;
  end

  assign memAddr = addrReg;
  assign memRdEn = strb.capture;
  assign dstWe   = strb.capture;
  assign dstData = memData[DATA_W-1:0];

  // R6: the high byte register moves only on a completing cycle
  a_r6_tblh_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> $stable(tblHigh));
  // R3: a last-page read lands in the top page
  a_r3_last_page: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadAddr && strb.forceLast) |=> (memAddr[ADDR_W-1 -: PAGE_W] == {PAGE_W{1'b1}}));
  // R1: a current-page read without the high pointer uses the PC page
  a_r1_cur_page: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadAddr && !strb.forceLast && !hiPtrEn) |=>
      (memAddr[ADDR_W-1 -: PAGE_W] == $past(pcPage)));
  // R8: the address register is frozen while a read completes
  a_r8_addr_frozen: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> $stable(memAddr));
endmodule

// File: rtl/tbl_read_unit.sv
module tbl_read_unit
  import tbl_read_pkg::*;
#(
  parameter int PAGE_W = 4,
  parameter int PTR_W  = 8,
  parameter int WORD_W = 16,
  parameter int DATA_W = 8,
  localparam int ADDR_W = PAGE_W + PTR_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdCurPage,
  input  logic              rdLastPage,
  input  logic              hiPtrEn,
  input  logic [PAGE_W-1:0] pcPage,
  input  logic [PTR_W-1:0]  tblPtrLo,
  input  logic [PTR_W-1:0]  tblPtrHi,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRdEn,
  input  logic [WORD_W-1:0] memData,
  output logic              busy,
  output logic              dstWe,
  output logic [DATA_W-1:0] dstData,
  output logic [DATA_W-1:0] tblHigh
);
  tblStrobe_t strb;

  tbl_read_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .rdCurPage(rdCurPage), .rdLastPage(rdLastPage),
    .strb(strb), .busy(busy)
  );

  tbl_read_dp #(
    .PAGE_W(PAGE_W), .PTR_W(PTR_W), .WORD_W(WORD_W), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .hiPtrEn(hiPtrEn),
    .pcPage(pcPage), .tblPtrLo(tblPtrLo), .tblPtrHi(tblPtrHi),
    .memData(memData), .memAddr(memAddr), .memRdEn(memRdEn),
    .dstWe(dstWe), .dstData(dstData), .tblHigh(tblHigh)
  );
endmodule

// File: tb/tbl_read_unit_tb.sv
module tbl_read_unit_tb;
  logic clk = 0, rstN = 0;
  logic rdCurPage = 0, rdLastPage = 0, hiPtrEn = 0;
  logic [3:0] pcPage = 0;
  logic [7:0] tblPtrLo = 0, tblPtrHi = 0;
  logic [11:0] memAddr;
  logic memRdEn, busy, dstWe;
  logic [15:0] memData;
  logic [7:0] dstData, tblHigh;
  int nChk = 0, nFail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  function automatic logic [15:0] memWord(input logic [11:0] a);
    return {a[7:0] ^ 8'hA5, a[11:4]};
  endfunction
  assign memData = memWord(memAddr);

  tbl_read_unit u_dut (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one full read; strobes driven at a falling edge
  task automatic doRead(input string req, input bit cur, input bit last, input bit en,
                        input logic [3:0] pc, input logic [7:0] lo, input logic [7:0] hi,
                        input logic [11:0] expAddr);
    logic [15:0] w;
    w = memWord(expAddr);
    @(negedge clk);
    rdCurPage = cur; rdLastPage = last; hiPtrEn = en;
    pcPage = pc; tblPtrLo = lo; tblPtrHi = hi;
    @(negedge clk);  // middle of second cycle
    rdCurPage = 0; rdLastPage = 0;
    chk({req, " addr"}, {4'h0, memAddr}, {4'h0, expAddr});
    chk("R7 busy", {15'h0, busy}, 16'h1);
    chk("R7 memRdEn", {15'h0, memRdEn}, 16'h1);
    chk("R5 dstWe", {15'h0, dstWe}, 16'h1);
    chk("R5 dstData", {8'h0, dstData}, {8'h0, w[7:0]});
    @(negedge clk);
    chk("R6 tblHigh", {8'h0, tblHigh}, {8'h0, w[15:8]});
    chk("R7 busy off", {15'h0, busy}, 16'h0);
    chk("R5 dstWe off", {15'h0, dstWe}, 16'h0);
  endtask

  task automatic testReset();
    chk("R10 busy", {15'h0, busy}, 16'h0);
    chk("R10 memRdEn", {15'h0, memRdEn}, 16'h0);
    chk("R10 dstWe", {15'h0, dstWe}, 16'h0);
    chk("R10 tblHigh", {8'h0, tblHigh}, 16'h0);
    chk("R10 memAddr", {4'h0, memAddr}, 16'h0);
  endtask

  task automatic testModes();
    doRead("R1", 1, 0, 0, 4'h3, 8'h12, 8'h07, 12'h312);
    doRead("R1", 1, 0, 0, 4'hA, 8'hFF, 8'h00, 12'hAFF);
    doRead("R4", 1, 0, 0, 4'h5, 8'h40, 8'hFE, 12'h540);
    doRead("R2", 1, 0, 1, 4'h5, 8'h06, 8'hE9, 12'h906);
    doRead("R2", 1, 0, 1, 4'hF, 8'h00, 8'h02, 12'h200);
    doRead("R3", 0, 1, 0, 4'h1, 8'h06, 8'h02, 12'hF06);
    doRead("R3", 0, 1, 1, 4'h0, 8'h05, 8'h03, 12'hF05);
    doRead("R9", 1, 1, 1, 4'h2, 8'h77, 8'h04, 12'hF77);
  endtask

  task automatic testHold();
    logic [7:0] held;
    held = tblHigh;
    repeat (3) @(negedge clk);
    chk("R6 hold", {8'h0, tblHigh}, {8'h0, held});
    chk("R5 idle dstWe", {15'h0, dstWe}, 16'h0);
  endtask

  task automatic testBusyIgnore();
    logic [7:0] held;
    @(negedge clk);
    rdCurPage = 1; hiPtrEn = 0; pcPage = 4'h6; tblPtrLo = 8'h21; tblPtrHi = 0;
    @(negedge clk);
    // still in second cycle: change pointers, keep a strobe high
    rdLastPage = 1; tblPtrLo = 8'h99;
    chk("R8 addr first", {4'h0, memAddr}, 16'h0621);
    @(negedge clk);
    rdCurPage = 0; rdLastPage = 0;
    held = tblHigh;
    chk("R8 no restart", {15'h0, busy}, 16'h0);
    chk("R8 addr kept", {4'h0, memAddr}, 16'h0621);
    chk("R8 tblHigh", {8'h0, held}, {8'h0, memWord(12'h621) >> 8});
    @(negedge clk);
    chk("R8 still idle", {15'h0, busy}, 16'h0);
    chk("R8 tblHigh kept", {8'h0, tblHigh}, {8'h0, held});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1;
    @(negedge clk);
    testReset();
    testModes();
    testHold();
    testBusyIgnore();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        nChk++; nFail++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule